// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Bits

This block holds a table of interrupt message descriptors and a bit array of pending vectors inside one 4 KB register region. Software programs each vector's message address, message data and mask through a 32-bit register port. Each vector has its own interrupt request input. A rising edge on a request either produces one message write request (64-bit address, 32-bit data) on a valid/ready output, or leaves the vector marked pending when something blocks delivery.

Delivery is blocked by the vector's own mask bit, by a function-wide mask input, or by the function enable input being low. It is also held back while an earlier message still waits on the output. A pending vector is looked at again after any software write into its table entry, and after a rescan pulse. The rescan walks every vector from index 0 upward and sends each one that is pending and no longer blocked. Software can read the pending bits but cannot write them.

Top module: `msix_vec_unit`

## Requirements
- R1: After reset every table word reads zero, every pending bit reads zero, and `msg_valid` is low.
- R2: Entry v occupies byte offsets 16*v to 16*v+15. Word 0 is message address low, word 1 is message address high, word 2 is message data and word 3 is vector control. Each word reads back the value last written to it.
- R3: A delivered message carries the address {address high, address low with bits 1:0 forced to 0} and the entry's data word.
- R4: Only a low-to-high transition of a request input counts. A request held high produces exactly one message.
- R5: A request on a vector whose control bit 0 is 1, or while `func_mask` is 1, sets that vector's pending bit and sends nothing.
- R6: Delivering a vector clears its pending bit.
- R7: The pending bit of vector v reads as bit (v mod 32) of the 32-bit word at byte offset 0x800 + 4*(v/32). This is bit (v mod 8) of byte 0x800 + v/8.
- R8: A write at byte offset 0x800 or above completes without error and changes no pending bit.
- R9: A write into entry v makes the block re-examine vector v. If that vector is then pending and unblocked, it is delivered.
- R10: A one-cycle `rescan` pulse delivers every pending, unblocked vector, in ascending index order.
- R11: An access whose byte enables are not all ones returns `rsp_err` = 1 and leaves storage unchanged.
- R12: While `msg_valid` is high and `msg_ready` is low, the message is held stable and no other message starts. Requests that arrive meanwhile are delivered afterwards.
- R13: While `func_en` is low, no message starts. Requests that arrive then are kept as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_en | input | 1 | Function-wide enable for message delivery |
| func_mask | input | 1 | Function-wide mask |
| rescan | input | 1 | Pulse: re-examine all vectors |
| irq | input | NUM_VEC | Per-vector interrupt request levels |
| req_valid | input | 1 | Register access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_woff | input | 10 | Word offset in the 4 KB region (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access rejected |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Receiver accepts message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench programs the address low words with bits 1:0 set. A design that does not clear those bits delivers addresses ending in 3. It holds a request high for many cycles, which a level-sensitive design answers with a burst of messages. It leaves vectors pending under each of the three blocking conditions, then checks that only the proper trigger releases each one: an entry write, or a rescan. A rescan must deliver in ascending order, so a wrong priority encoder shows up as swapped messages. It also stalls the output while further requests arrive, which exposes a design that drops those requests or lets the held message change. Writes to the pending region and partial byte-enable writes are read back afterwards, so a design that lets either one touch storage is caught.

// File: rtl/msix_pkg.sv
package msix_pkg;

  localparam int WORD_W  = 32;
  localparam int WOFF_W  = 10;
  localparam int MAX_VEC = 128;

  typedef enum logic [1:0] {
    WSEL_ADDR_LO = 2'd0,
    WSEL_ADDR_HI = 2'd1,
    WSEL_DATA    = 2'd2,
    WSEL_CTRL    = 2'd3
  } word_sel_e;

  // Compose the delivered address; the two lowest bits are always zero.
  function automatic logic [63:0] msg_address(input logic [31:0] hi,
                                              input logic [29:0] lo_upper);
    return {hi, lo_upper, 2'b00};
  endfunction

  // Word offset falls in the upper half (pending array).
  function automatic logic is_pend_region(input logic [WOFF_W-1:0] woff);
    return woff[WOFF_W-1];
  endfunction

  // Table entry index addressed by a word offset (16 bytes per entry).
  function automatic logic [6:0] entry_of(input logic [WOFF_W-1:0] woff);
    return woff[8:2];
  endfunction

endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int IDX_W  = $clog2(NUM_VEC),
  localparam int NPW    = (NUM_VEC + 31) / 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [WOFF_W-1:0]   req_woff,
  input  logic [31:0]         req_wdata,
  input  logic [3:0]          req_be,
  input  logic [NUM_VEC-1:0]  pend,
  input  logic [IDX_W-1:0]    sel_idx,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic                rsp_err,
  output logic                wr_hit,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [NUM_VEC-1:0]  vmask,
  output logic [63:0]         sel_addr,
  output logic [31:0]         sel_data
);

  logic [31:0] lo_q  [NUM_VEC];
  logic [31:0] hi_q  [NUM_VEC];
  logic [31:0] dat_q [NUM_VEC];
  logic [31:0] ctl_q [NUM_VEC];

  logic              full_be;
  logic              in_pend;
  logic              idx_ok;
  logic [IDX_W-1:0]  tbl_idx;
  word_sel_e         wsel;
  logic              wr_acc;
  logic [NPW*32-1:0] pend_pad;
  logic [31:0]       rd;

  assign full_be = &req_be;
  assign in_pend = is_pend_region(req_woff);
  assign idx_ok  = int'(entry_of(req_woff)) < NUM_VEC;
  assign tbl_idx = req_woff[IDX_W+1:2];
  assign wsel    = word_sel_e'(req_woff[1:0]);
  assign wr_acc  = req_valid && req_write && full_be && !in_pend && idx_ok;

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend;
  end

  always_comb begin
    rd = '0;
    if (in_pend) begin
      for (int j = 0; j < NPW; j++) begin
        if (int'(req_woff[8:0]) == j) rd = pend_pad[j*32 +: 32];
      end
    end else if (idx_ok) begin
      case (wsel)
        WSEL_ADDR_LO: rd = lo_q[tbl_idx];
        WSEL_ADDR_HI: rd = hi_q[tbl_idx];
        WSEL_DATA:    rd = dat_q[tbl_idx];
        default:      rd = ctl_q[tbl_idx];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
        ctl_q[i] <= '0;
      end
    end else if (wr_acc) begin
      case (wsel)
        WSEL_ADDR_LO: lo_q[tbl_idx]  <= req_wdata;
        WSEL_ADDR_HI: hi_q[tbl_idx]  <= req_wdata;
        WSEL_DATA:    dat_q[tbl_idx] <= req_wdata;
        default:      ctl_q[tbl_idx] <= req_wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      wr_hit    <= 1'b0;
      wr_idx    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !full_be;
      rsp_rdata <= (req_valid && !req_write && full_be) ? rd : '0;
      wr_hit    <= wr_acc;
      wr_idx    <= tbl_idx;
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask
    assign vmask[g] = ctl_q[g][0];
  end

  assign sel_addr = msg_address(hi_q[sel_idx], lo_q[sel_idx][31:2]);
  assign sel_data = dat_q[sel_idx];

endmodule

// File: rtl/msix_pend_sched.sv
module msix_pend_sched #(
  parameter int NUM_VEC = 8,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq,
  input  logic               rescan,
  input  logic               wr_hit,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [NUM_VEC-1:0] vmask,
  input  logic               func_en,
  input  logic               func_mask,
  input  logic               out_busy,
  output logic [NUM_VEC-1:0] irq_edge,
  output logic [NUM_VEC-1:0] pend,
  output logic               fire,
  output logic [IDX_W-1:0]   fire_idx
);

  logic [NUM_VEC-1:0] irq_q;
  logic [NUM_VEC-1:0] chk_q;
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] chk_nxt;
  logic [NUM_VEC-1:0] pend_nxt;
  logic [IDX_W-1:0]   pick;
  logic               consume;

  assign irq_edge = irq & ~irq_q;

  // Lowest-index vector awaiting examination wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (chk_q[i]) pick = IDX_W'(i);
    end
  end

  assign consume  = (|chk_q) && !out_busy;
  assign fire     = consume && pend_q[pick] && !vmask[pick] && func_en && !func_mask;
  assign fire_idx = pick;

  always_comb begin
    chk_nxt  = chk_q;
    pend_nxt = pend_q;
    if (consume) chk_nxt[pick] = 1'b0;
    if (fire)    pend_nxt[pick] = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (irq_edge[i] || rescan || (wr_hit && (int'(wr_idx) == i))) chk_nxt[i] = 1'b1;
      if (irq_edge[i]) pend_nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      chk_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq;
      chk_q  <= chk_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/msix_msg_out.sv
module msix_msg_out (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic [63:0] fire_addr,
  input  logic [31:0] fire_data,
  input  logic        msg_ready,
  output logic        msg_valid,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (fire) begin
      msg_valid <= 1'b1;
      msg_addr  <= fire_addr;
      msg_data  <= fire_data;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/msix_vec_unit.sv
module msix_vec_unit
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               func_en,
  input  logic               func_mask,
  input  logic               rescan,
  input  logic [NUM_VEC-1:0] irq,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [9:0]         req_woff,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_be,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);

  // Internal events, named for the checker.
  logic [NUM_VEC-1:0] pend_vec;
  logic [NUM_VEC-1:0] vmask_vec;
  logic [NUM_VEC-1:0] irq_edge;
  logic               wr_hit;
  logic [IDX_W-1:0]   wr_idx;
  logic               fire;
  logic [IDX_W-1:0]   fire_idx;
  logic [63:0]        sel_addr;
  logic [31:0]        sel_data;

  msix_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_woff  (req_woff),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .pend      (pend_vec),
    .sel_idx   (fire_idx),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .wr_hit    (wr_hit),
    .wr_idx    (wr_idx),
    .vmask     (vmask_vec),
    .sel_addr  (sel_addr),
    .sel_data  (sel_data)
  );

  msix_pend_sched #(.NUM_VEC(NUM_VEC)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .rescan    (rescan),
    .wr_hit    (wr_hit),
    .wr_idx    (wr_idx),
    .vmask     (vmask_vec),
    .func_en   (func_en),
    .func_mask (func_mask),
    .out_busy  (msg_valid),
    .irq_edge  (irq_edge),
    .pend      (pend_vec),
    .fire      (fire),
    .fire_idx  (fire_idx)
  );

  msix_msg_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fire_addr (sel_addr),
    .fire_data (sel_data),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

endmodule

// File: rtl/msix_vec_unit_chk.sv
module msix_vec_unit_chk #(
  parameter int NUM_VEC = 8,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               func_en,
  input logic               func_mask,
  input logic               req_valid,
  input logic               req_write,
  input logic [9:0]         req_woff,
  input logic [3:0]         req_be,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [NUM_VEC-1:0] pend_vec,
  input logic [NUM_VEC-1:0] vmask_vec,
  input logic [NUM_VEC-1:0] irq_edge,
  input logic               wr_hit,
  input logic               fire,
  input logic [IDX_W-1:0]   fire_idx
);

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[1:0] == 2'b00));

  p_edge_sets_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_edge) |=> ((pend_vec & $past(irq_edge)) == $past(irq_edge)));

  p_fire_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !vmask_vec[fire_idx]);

  p_fire_clears_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !irq_edge[fire_idx]) |=> !pend_vec[$past(fire_idx)]);

  p_pend_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_woff[9] && (req_be == 4'hF)) |=> (!wr_hit && !rsp_err));

  p_partial_be_rejected_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_be != 4'hF)) |=> (rsp_err && !wr_hit));

  p_hold_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  p_single_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !msg_valid);

  p_fire_enabled_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (func_en && !func_mask));

endmodule

bind msix_vec_unit msix_vec_unit_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .func_en   (func_en),
  .func_mask (func_mask),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_woff  (req_woff),
  .req_be    (req_be),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .pend_vec  (pend_vec),
  .vmask_vec (vmask_vec),
  .irq_edge  (irq_edge),
  .wr_hit    (wr_hit),
  .fire      (fire),
  .fire_idx  (fire_idx)
);

// File: tb/msix_vec_unit_test.sv
module msix_vec_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          func_en = 1'b0;
  logic          func_mask = 1'b0;
  logic          rescan = 1'b0;
  logic [NV-1:0] irq = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [9:0]    req_woff = '0;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_be = 4'hF;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          rsp_err;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  typedef struct packed {
    logic [63:0] a;
    logic [31:0] d;
    logic [7:0]  tag;
  } exp_t;

  exp_t q[$];
  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  msix_vec_unit #(.NUM_VEC(NV)) uut (.*);

  function automatic logic [31:0] lo_of(input int v);
    return 32'hFEE0_0003 | (32'(v) << 4);
  endfunction
  function automatic logic [31:0] hi_of(input int v);
    return 32'h0000_1000 + 32'(v);
  endfunction
  function automatic logic [31:0] dat_of(input int v);
    return 32'h0000_A000 + 32'(v);
  endfunction
  // Expected address: high word on top, low word with bits 1:0 cleared.
  function automatic exp_t exp_of(input int v, input int tag);
    exp_t e;
    e.a = {hi_of(v), lo_of(v) & 32'hFFFF_FFFC};
    e.d = dat_of(v);
    e.tag = 8'(tag);
    return e;
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  // Scoreboard monitor: a handshake happens at the next edge.
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R5 unexpected message actual %h expected none", msg_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(msg_addr == e.a, $sformatf("R%0d message address", e.tag), msg_addr, e.a);
        check(msg_data == e.d, $sformatf("R%0d message data", e.tag), 64'(msg_data), 64'(e.d));
      end
    end
  end

  task automatic bus_wr(input logic [11:0] off, input logic [31:0] d,
                        input logic [3:0] be, output logic err);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_woff = off[11:2];
    req_wdata = d; req_be = be;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
    err = rsp_err;
  endtask

  task automatic bus_rd(input logic [11:0] off, output logic [31:0] d, output logic err);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_woff = off[11:2]; req_be = 4'hF;
    @(posedge clk); #1;
    req_valid = 1'b0;
    d = rsp_rdata;
    err = rsp_err;
  endtask

  task automatic irq_pulse(input int v, input int hold);
    @(posedge clk); #1; irq[v] = 1'b1;
    repeat (hold) @(posedge clk);
    #1; irq[v] = 1'b0;
  endtask

  task automatic do_rescan();
    @(posedge clk); #1; rescan = 1'b1;
    @(posedge clk); #1; rescan = 1'b0;
  endtask

  task automatic drain(input string what);
    repeat (15) @(posedge clk);
    #1;
    check(q.size() == 0, what, 64'(q.size()), 64'd0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    logic [63:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check(msg_valid == 1'b0, "R1 msg_valid after reset", 64'(msg_valid), 64'd0);
    bus_rd(12'h000, rd, er);
    check(rd == 32'h0, "R1 entry 0 address low", 64'(rd), 64'd0);
    bus_rd(12'h07C, rd, er);
    check(rd == 32'h0, "R1 entry 7 control", 64'(rd), 64'd0);
    bus_rd(12'h800, rd, er);
    check(rd == 32'h0, "R1 pending array", 64'(rd), 64'd0);

    // R2: program all entries, read one back word by word
    for (int v = 0; v < NV; v++) begin
      bus_wr(12'(16 * v + 0), lo_of(v), 4'hF, er);
      bus_wr(12'(16 * v + 4), hi_of(v), 4'hF, er);
      bus_wr(12'(16 * v + 8), dat_of(v), 4'hF, er);
      bus_wr(12'(16 * v + 12), 32'h0, 4'hF, er);
    end
    bus_rd(12'h030, rd, er);
    check(rd == lo_of(3), "R2 entry 3 word 0", 64'(rd), 64'(lo_of(3)));
    check(er == 1'b0, "R2 full-width read no error", 64'(er), 64'd0);
    bus_rd(12'h034, rd, er);
    check(rd == hi_of(3), "R2 entry 3 word 1", 64'(rd), 64'(hi_of(3)));
    bus_rd(12'h038, rd, er);
    check(rd == dat_of(3), "R2 entry 3 word 2", 64'(rd), 64'(dat_of(3)));
    bus_wr(12'h03C, 32'h0000_0100, 4'hF, er);
    bus_rd(12'h03C, rd, er);
    check(rd == 32'h0000_0100, "R2 entry 3 word 3", 64'(rd), 64'h100);
    drain("R1 no message while nothing pending");

    // R3 R4 R6: unmasked delivery, request held high
    func_en = 1'b1;
    q.push_back(exp_of(2, 3));
    irq_pulse(2, 10);
    drain("R4 held request gives one message");
    bus_rd(12'h800, rd, er);
    check(rd == 32'h0, "R6 pending clear after delivery", 64'(rd), 64'd0);

    // R5 R7: vector mask latches pending
    bus_wr(12'h05C, 32'h1, 4'hF, er);
    irq_pulse(5, 2);
    drain("R5 masked vector sends nothing");
    bus_rd(12'h800, rd, er);
    check(rd == 32'h0000_0020, "R7 pending bit 5", 64'(rd), 64'h20);

    // R9: unmasking through the table delivers it
    q.push_back(exp_of(5, 9));
    bus_wr(12'h05C, 32'h0, 4'hF, er);
    drain("R9 table write delivers pending vector");
    bus_rd(12'h800, rd, er);
    check(rd == 32'h0, "R6 pending cleared after R9 delivery", 64'(rd), 64'd0);

    // R5 R10: function mask, then rescan in ascending order
    func_mask = 1'b1;
    irq_pulse(6, 2);
    irq_pulse(1, 2);
    drain("R5 function mask sends nothing");
    bus_rd(12'h800, rd, er);
    check(rd == 32'h0000_0042, "R7 pending bits 1 and 6", 64'(rd), 64'h42);
    func_mask = 1'b0;
    drain("R10 nothing without rescan");
    q.push_back(exp_of(1, 10));
    q.push_back(exp_of(6, 10));
    do_rescan();
    drain("R10 rescan delivers both");

    // R13 R8: disabled function, pending write ignored
    func_en = 1'b0;
    irq_pulse(4, 2);
    drain("R13 disabled function sends nothing");
    bus_rd(12'h800, rd, er);
    check(rd == 32'h0000_0010, "R13 pending kept while disabled", 64'(rd), 64'h10);
    bus_wr(12'h800, 32'h0, 4'hF, er);
    check(er == 1'b0, "R8 pending write no error", 64'(er), 64'd0);
    bus_wr(12'h804, 32'hFFFF_FFFF, 4'hF, er);
    bus_rd(12'h800, rd, er);
    check(rd == 32'h0000_0010, "R8 pending unchanged by write", 64'(rd), 64'h10);
    func_en = 1'b1;
    q.push_back(exp_of(4, 13));
    do_rescan();
    drain("R13 delivered after enable and rescan");

    // R11: partial byte enables
    bus_wr(12'h008, 32'hDEAD_BEEF, 4'h3, er);
    check(er == 1'b1, "R11 partial write error", 64'(er), 64'd1);
    bus_rd(12'h008, rd, er);
    check(rd == dat_of(0), "R11 storage unchanged", 64'(rd), 64'(dat_of(0)));

    // R12: output stall
    @(posedge clk); #1 msg_ready = 1'b0;
    q.push_back(exp_of(0, 12));
    q.push_back(exp_of(7, 12));
    irq_pulse(0, 1);
    irq_pulse(7, 1);
    repeat (4) @(posedge clk);
    #1;
    held = exp_of(0, 12).a;
    check(msg_valid == 1'b1, "R12 message held valid", 64'(msg_valid), 64'd1);
    check(msg_addr == held, "R12 held message address", msg_addr, held);
    repeat (3) @(posedge clk);
    #1;
    check(msg_addr == held && msg_valid, "R12 held message stable", msg_addr, held);
    msg_ready = 1'b1;
    drain("R12 both delivered after stall");

    summary();
    $finish;
  end

endmodule